// File: doc/BRIEF.md
# CAN Fault Confinement Controller

This block keeps the error standing of a CAN node. Two counters record the health of the node: one for transmission and one for reception. Upstream logic classifies each bus event and reports it with a single-cycle strobe. The strobes are transmit error, transmit success, receive error and receive success. From the counter values the block derives one of three states: error-active, error-passive or bus-off. It also raises a one-cycle status interrupt whenever the passive flag or the bus-off flag changes, provided the interrupt enable is high.

While the node is bus-off, upstream logic sends a strobe for every run of eleven recessive bits it sees. When the configured number of such runs has been counted, the node returns to error-active and both counters restart from zero. Bit timing, frame decoding, error detection and any register access belong to other blocks.

Top module: `can_fault_conf`

## Requirements
- R1: A synchronous reset sets both counters and the recovery run count to zero, selects error-active, and holds the interrupt low.
- R2: Outside bus-off, a transmit error strobe adds 8 to the transmit counter. A transmit success strobe subtracts 1 from it, but never takes it below zero. When both strobes arrive in the same cycle, the error wins.
- R3: Outside bus-off, a receive error strobe adds 1 to the receive counter, which saturates at 255. A receive success strobe subtracts 1 while the counter is at or below 127, but never takes it below zero. When both strobes arrive in the same cycle, the error wins.
- R4: A receive success strobe while the receive counter is above 127 loads the counter with 120.
- R5: The passive flag rises on the same clock edge that takes either counter above 127, as long as the transmit counter stays at or below 255.
- R6: The passive flag falls on the edge that leaves both counters below 128.
- R7: On the edge that takes the transmit counter above 255, the bus-off flag rises and the passive flag falls. The two flags are never high together.
- R8: While bus-off, all transmit and receive strobes are ignored and both counters hold their values.
- R9: Recessive-run strobes that arrive outside bus-off are ignored; they do not shorten a later recovery.
- R10: While bus-off, the 128th recessive-run strobe clears the bus-off flag and both counters on the same edge.
- R11: When the interrupt enable is high, a change of the passive flag or of the bus-off flag raises the interrupt for exactly the cycle in which the new flag value is first visible. When the enable is low, no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tx_err_i | input | 1 | Transmit error strobe |
| tx_ok_i | input | 1 | Transmit success strobe |
| rx_err_i | input | 1 | Receive error strobe |
| rx_ok_i | input | 1 | Receive success strobe |
| run11_i | input | 1 | One run of eleven recessive bits seen |
| irq_en_i | input | 1 | Status interrupt enable |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| passive_o | output | 1 | Error-passive flag |
| busoff_o | output | 1 | Bus-off flag |
| irq_o | output | 1 | Status change interrupt pulse |

## Verification
Two things can happen in the same cycle: the transmit counter crosses into bus-off, and a receive event updates the other counter. The bench provokes this by driving the final transmit error strobe together with a receive error strobe while the transmit counter is at 248. The result is judged correct when the transmit counter reads 256, the receive counter has also advanced by one, bus-off is set, the passive flag is clear and a single interrupt pulse appears. The bench then confirms that strobes arriving after that edge are ignored.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
   typedef enum logic [1:0] {
      FC_ACTIVE  = 2'd0,
      FC_PASSIVE = 2'd1,
      FC_BUSOFF  = 2'd2
   } fc_state_e;
endpackage

// File: rtl/fc_tec_unit.sv
module fc_tec_unit #(
   parameter int W    = 9,
   parameter int STEP = 8
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         clr_i,
   input  logic         hold_i,
   input  logic         err_i,
   input  logic         ok_i,
   output logic [W-1:0] cnt_o,
   output logic [W-1:0] cnt_nxt_o
);
   localparam logic [W-1:0] STEP_V = W'(STEP);
   logic [W-1:0] cnt_q;

   always_comb begin
      cnt_nxt_o = cnt_q;
      if (clr_i)
         cnt_nxt_o = '0;
      else if (!hold_i) begin
         if (err_i)
            cnt_nxt_o = cnt_q + STEP_V;
         else if (ok_i && cnt_q != '0)
            cnt_nxt_o = cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) cnt_q <= '0;
      else       cnt_q <= cnt_nxt_o;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/fc_rec_unit.sv
module fc_rec_unit #(
   parameter int W          = 8,
   parameter int PASSIVE_TH = 128,
   parameter int RELOAD     = 120
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         clr_i,
   input  logic         hold_i,
   input  logic         err_i,
   input  logic         ok_i,
   output logic [W-1:0] cnt_o,
   output logic [W-1:0] cnt_nxt_o
);
   localparam logic [W-1:0] TH_V     = W'(PASSIVE_TH);
   localparam logic [W-1:0] RELOAD_V = W'(RELOAD);
   localparam logic [W-1:0] MAX_V    = '1;
   logic [W-1:0] cnt_q;

   always_comb begin
      cnt_nxt_o = cnt_q;
      if (clr_i)
         cnt_nxt_o = '0;
      else if (!hold_i) begin
         if (err_i) begin
            if (cnt_q != MAX_V) cnt_nxt_o = cnt_q + 1'b1;
         end else if (ok_i) begin
            if (cnt_q >= TH_V)        cnt_nxt_o = RELOAD_V;
            else if (cnt_q != '0)     cnt_nxt_o = cnt_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) cnt_q <= '0;
      else       cnt_q <= cnt_nxt_o;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/fc_recovery.sv
module fc_recovery #(
   parameter int RUNS = 128
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic busoff_i,
   input  logic run_i,
   output logic done_o
);
   localparam int CW = (RUNS > 2) ? $clog2(RUNS) : 1;
   localparam logic [CW-1:0] LAST_V = CW'(RUNS - 1);
   logic [CW-1:0] runs_q;

   assign done_o = busoff_i && run_i && (runs_q == LAST_V);

   always_ff @(posedge clk_i) begin
      if (rst_i || !busoff_i)
         runs_q <= '0;
      else if (run_i)
         runs_q <= done_o ? '0 : runs_q + 1'b1;
   end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
   import can_fc_pkg::*;
#(
   parameter int TEC_W       = 9,
   parameter int REC_W       = 8,
   parameter int TX_ERR_STEP = 8,
   parameter int PASSIVE_TH  = 128,
   parameter int BUSOFF_TH   = 256,
   parameter int RX_RELOAD   = 120,
   parameter int RECOV_RUNS  = 128
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             tx_err_i,
   input  logic             tx_ok_i,
   input  logic             rx_err_i,
   input  logic             rx_ok_i,
   input  logic             run11_i,
   input  logic             irq_en_i,
   output logic [TEC_W-1:0] tec_o,
   output logic [REC_W-1:0] rec_o,
   output logic             passive_o,
   output logic             busoff_o,
   output logic             irq_o
);
   localparam logic [TEC_W-1:0] TEC_TH_V  = TEC_W'(PASSIVE_TH);
   localparam logic [REC_W-1:0] REC_TH_V  = REC_W'(PASSIVE_TH);
   localparam logic [TEC_W-1:0] TEC_OFF_V = TEC_W'(BUSOFF_TH);

   if (RX_RELOAD < PASSIVE_TH - 9 || RX_RELOAD >= PASSIVE_TH) begin : g_bad_reload
      $error("RX_RELOAD must lie just below PASSIVE_TH");
   end
   if ((1 << TEC_W) < BUSOFF_TH + TX_ERR_STEP) begin : g_bad_tec_w
      $error("TEC_W too narrow for bus-off overshoot");
   end
   if ((1 << REC_W) <= PASSIVE_TH) begin : g_bad_rec_w
      $error("REC_W too narrow for passive threshold");
   end
   if (RECOV_RUNS < 2) begin : g_bad_runs
      $error("RECOV_RUNS must be at least 2");
   end

   fc_state_e        state_q, state_d;
   logic [TEC_W-1:0] tec_nxt;
   logic [REC_W-1:0] rec_nxt;
   logic             recov_done;
   logic             is_busoff;
   logic             irq_q;

   assign is_busoff = (state_q == FC_BUSOFF);

   fc_tec_unit #(.W(TEC_W), .STEP(TX_ERR_STEP)) u_tec (
      .clk_i(clk_i), .rst_i(rst_i), .clr_i(recov_done), .hold_i(is_busoff),
      .err_i(tx_err_i), .ok_i(tx_ok_i), .cnt_o(tec_o), .cnt_nxt_o(tec_nxt));

   fc_rec_unit #(.W(REC_W), .PASSIVE_TH(PASSIVE_TH), .RELOAD(RX_RELOAD)) u_rec (
      .clk_i(clk_i), .rst_i(rst_i), .clr_i(recov_done), .hold_i(is_busoff),
      .err_i(rx_err_i), .ok_i(rx_ok_i), .cnt_o(rec_o), .cnt_nxt_o(rec_nxt));

   fc_recovery #(.RUNS(RECOV_RUNS)) u_recov (
      .clk_i(clk_i), .rst_i(rst_i), .busoff_i(is_busoff),
      .run_i(run11_i), .done_o(recov_done));

   always_comb begin
      if (recov_done)                                 state_d = FC_ACTIVE;
      else if (is_busoff)                             state_d = FC_BUSOFF;
      else if (tec_nxt >= TEC_OFF_V)                  state_d = FC_BUSOFF;
      else if (tec_nxt >= TEC_TH_V || rec_nxt >= REC_TH_V) state_d = FC_PASSIVE;
      else                                            state_d = FC_ACTIVE;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= FC_ACTIVE;
         irq_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         irq_q   <= irq_en_i && (state_d != state_q);
      end
   end

   assign passive_o = (state_q == FC_PASSIVE);
   assign busoff_o  = is_busoff;
   assign irq_o     = irq_q;
endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk #(
   parameter int TEC_W       = 9,
   parameter int REC_W       = 8,
   parameter int TX_ERR_STEP = 8,
   parameter int PASSIVE_TH  = 128,
   parameter int RX_RELOAD   = 120
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             tx_err_i,
   input logic             rx_err_i,
   input logic             rx_ok_i,
   input logic             run11_i,
   input logic             irq_en_i,
   input logic [TEC_W-1:0] tec_o,
   input logic [REC_W-1:0] rec_o,
   input logic             passive_o,
   input logic             busoff_o,
   input logic             irq_o
);
   localparam logic [TEC_W-1:0] STEP_V   = TEC_W'(TX_ERR_STEP);
   localparam logic [TEC_W-1:0] TEC_TH_V = TEC_W'(PASSIVE_TH);
   localparam logic [REC_W-1:0] REC_TH_V = REC_W'(PASSIVE_TH);
   localparam logic [REC_W-1:0] RELOAD_V = REC_W'(RX_RELOAD);
   localparam logic [REC_W-1:0] MAX_V    = '1;

   AST_TX_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
      (!busoff_o && tx_err_i) |=> (tec_o == $past(tec_o) + STEP_V)); // R2
   AST_RX_SATURATE: assert property (@(posedge clk_i) disable iff (rst_i)
      (!busoff_o && rx_err_i && rec_o == MAX_V) |=> (rec_o == MAX_V)); // R3
   AST_RX_RELOAD: assert property (@(posedge clk_i) disable iff (rst_i)
      (!busoff_o && rx_ok_i && !rx_err_i && rec_o >= REC_TH_V) |=> (rec_o == RELOAD_V)); // R4
   AST_PASSIVE_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
      !busoff_o |-> (passive_o == (tec_o >= TEC_TH_V || rec_o >= REC_TH_V))); // R5
   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (rst_i)
      !(busoff_o && passive_o)); // R7
   AST_BUSOFF_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
      (busoff_o && !run11_i) |=> ($stable(tec_o) && $stable(rec_o) && busoff_o)); // R8
   AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
      irq_o |-> ($past(irq_en_i) && (passive_o != $past(passive_o) || busoff_o != $past(busoff_o)))); // R11
endmodule

bind can_fault_conf can_fault_conf_chk #(
   .TEC_W(TEC_W), .REC_W(REC_W), .TX_ERR_STEP(TX_ERR_STEP),
   .PASSIVE_TH(PASSIVE_TH), .RX_RELOAD(RX_RELOAD)
) u_chk (
   .clk_i(clk_i), .rst_i(rst_i), .tx_err_i(tx_err_i), .rx_err_i(rx_err_i),
   .rx_ok_i(rx_ok_i), .run11_i(run11_i), .irq_en_i(irq_en_i), .tec_o(tec_o),
   .rec_o(rec_o), .passive_o(passive_o), .busoff_o(busoff_o), .irq_o(irq_o));

// File: tb/can_fault_conf_bench.sv
module can_fault_conf_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tx_err = 0, tx_ok = 0, rx_err = 0, rx_ok = 0, run11 = 0, irq_en = 1;
   logic [8:0] tec;
   logic [7:0] rec;
   logic       passive, busoff, irq;
   int         n_cmp = 0, n_bad = 0;
   bit         finished = 0;

   always #10 clk = ~clk;

   can_fault_conf u_can_fault_conf (
      .clk_i(clk), .rst_i(rst), .tx_err_i(tx_err), .tx_ok_i(tx_ok),
      .rx_err_i(rx_err), .rx_ok_i(rx_ok), .run11_i(run11), .irq_en_i(irq_en),
      .tec_o(tec), .rec_o(rec), .passive_o(passive), .busoff_o(busoff), .irq_o(irq));

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input logic te, input logic to, input logic re,
                       input logic ro, input logic rn);
      @(negedge clk);
      tx_err = te; tx_ok = to; rx_err = re; rx_ok = ro; run11 = rn;
      @(negedge clk);
      tx_err = 0; tx_ok = 0; rx_err = 0; rx_ok = 0; run11 = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1;
      @(negedge clk); @(negedge clk); rst = 0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 tec", tec, 0); chk("R1 rec", rec, 0);
      chk("R1 passive", passive, 0); chk("R1 busoff", busoff, 0); chk("R1 irq", irq, 0);
   endtask

   task automatic t_tx_count();
      do_reset();
      step(0, 1, 0, 0, 0); chk("R2 floor", tec, 0);
      for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0);
      chk("R2 add", tec, 24);
      step(0, 1, 0, 0, 0); chk("R2 sub", tec, 23);
      step(1, 1, 0, 0, 0); chk("R2 err wins", tec, 31);
   endtask

   task automatic t_rx_count();
      do_reset();
      step(0, 0, 0, 1, 0); chk("R3 floor", rec, 0);
      for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0);
      chk("R3 add", rec, 5);
      step(0, 0, 0, 1, 0); chk("R3 sub", rec, 4);
      step(0, 0, 1, 1, 0); chk("R3 err wins", rec, 5);
      for (int i = 0; i < 300; i++) step(0, 0, 1, 0, 0);
      chk("R3 saturate", rec, 255); chk("R5 passive by rx", passive, 1);
      irq_en = 1;
      step(0, 0, 0, 1, 0);
      chk("R4 reload", rec, 120); chk("R6 passive clear", passive, 0);
      chk("R11 irq on clear", irq, 1);
      @(negedge clk); chk("R11 irq one cycle", irq, 0);
   endtask

   task automatic t_passive_tx();
      do_reset();
      irq_en = 1;
      for (int i = 0; i < 15; i++) step(1, 0, 0, 0, 0);
      chk("R5 below", passive, 0); chk("R11 no irq", irq, 0);
      step(1, 0, 0, 0, 0);
      chk("R5 tec", tec, 128); chk("R5 set", passive, 1); chk("R11 irq set", irq, 1);
      irq_en = 0;
      step(0, 1, 0, 0, 0);
      chk("R6 clear", passive, 0); chk("R11 masked", irq, 0);
      irq_en = 1;
   endtask

   task automatic t_busoff();
      do_reset();
      irq_en = 1;
      for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0);
      for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1);
      chk("R9 stray runs", busoff, 0); chk("R9 rec kept", rec, 3);
      for (int i = 0; i < 31; i++) step(1, 0, 0, 0, 0);
      chk("R5 tec 248", tec, 248); chk("R5 passive", passive, 1);
      step(1, 0, 1, 0, 0);
      chk("R7 tec", tec, 256); chk("R7 rec same cycle", rec, 4);
      chk("R7 busoff", busoff, 1); chk("R7 passive off", passive, 0); chk("R11 irq busoff", irq, 1);
      step(0, 1, 1, 0, 0);
      chk("R8 tec held", tec, 256); chk("R8 rec held", rec, 4);
      step(1, 0, 0, 1, 0);
      chk("R8 tec held2", tec, 256); chk("R8 rec held2", rec, 4);
      for (int i = 0; i < 127; i++) step(0, 0, 0, 0, 1);
      chk("R9 R10 still off after 127", busoff, 1);
      step(0, 0, 0, 0, 1);
      chk("R10 busoff clear", busoff, 0); chk("R10 tec zero", tec, 0);
      chk("R10 rec zero", rec, 0); chk("R10 active", passive, 0);
      chk("R11 irq recover", irq, 1);
      @(negedge clk); chk("R11 irq drop", irq, 0);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_tx_count();
      t_rx_count();
      t_passive_tx();
      t_busoff();
      summary();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
   end
endmodule